// File: doc/BRIEF.md
# Wide quad-PSRAM burst reader

This block fetches bursts of 32-bit words from four quad-I/O pseudo-static RAM chips. The chips sit side by side on one 16-bit data bus, and they share one serial clock and one chip select. Chip k owns data lanes [4k+3:4k]. The four chips therefore behave as a single device that returns one 16-bit beat on every serial clock.

A request carries a byte address and a word count. The controller puts the same command and address on every chip, waits the configured number of latency clocks and then lets go of the bus. It then captures one beat per rising edge and pairs the beats into 32-bit words. The words leave through a valid/ready write port together with their index inside the burst, ready to be stored in a destination buffer. When the last word has been accepted, a single-cycle done pulse ends the transaction. The serial clock runs at half the system clock. Each beat is sampled a fixed number of system cycles after its rising edge, which allows for the round trip through the pads.

Top module: `qpsram_burst_rd`

## Requirements
- R1: The first 8 serial clocks of a transaction carry a 32-bit header, most significant nibble first, one nibble per rising edge. The header's top byte is the read opcode 0xEB and its low 24 bits are the per-chip address, equal to the request byte address shifted right by 2.
- R2: On every header clock, bus bits [15:12], [11:8], [7:4] and [3:0] carry the same nibble.
- R3: The bus output enable is high during the 8 header clocks only and is already low at the first rising edge after the header.
- R4: Exactly WAIT_CLKS serial clocks (default 10) separate the last header clock from the first data clock.
- R5: A request for N words produces exactly 8 + WAIT_CLKS + 2N rising edges of the serial clock.
- R6: Word i of the burst (i = 0 to N-1) is written with wr_idx = i. The beat of data clock 2i forms bits [31:16] of the word and the beat of data clock 2i+1 forms bits [15:0]. Each beat is sampled SAMPLE_DLY system cycles after its rising edge. While wr_ready is low, wr_valid, wr_data and wr_idx hold.
- R7: The serial clock idles low. Chip select goes low before the first rising edge, stays low through every rising edge, and rises only after the last beat has been captured.
- R8: Every request loads its beat count from its own word count (N must be nonzero). A shorter request after a longer one produces only its own clocks and words.
- R9: A request is taken only while busy is low. Busy is high from the cycle after acceptance until the cycle in which done pulses. A request presented while busy has no effect.
- R10: Done is high for one cycle after the last word has been accepted at the write port. When done pulses, chip select is high and wr_valid is low.
- R11: After reset, chip select is high, the serial clock low, the output enable low, and busy, done and wr_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | ADDR_W | Byte address of the burst |
| req_words | input | LEN_W | Number of 32-bit words, nonzero |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| mem_sck | output | 1 | Serial clock shared by the four chips |
| mem_cs_n | output | 1 | Shared chip select, active low |
| mem_dq_o | output | 16 | Bus value driven during the header |
| mem_dq_oe | output | 1 | Bus output enable |
| mem_dq_i | input | 16 | Bus value returned by the chips |
| wr_valid | output | 1 | Word available for the destination buffer |
| wr_ready | input | 1 | Destination accepts the word |
| wr_idx | output | LEN_W | Word index within the burst |
| wr_data | output | 32 | Assembled 32-bit word |

## Verification
Rising edge k of the serial clock comes 2k-1 system cycles after the accepting edge. Header nibbles and output-enable levels are due at that edge, so the bench's chip model checks them at each rising edge of mem_sck. The model drives each beat 1 ns after its data clock rises. The controller samples it SAMPLE_DLY system cycles later, so a wrong sample point shows up directly as a data mismatch. Busy is due one cycle after acceptance, done and the fall of busy are due in the same cycle, and words are due whenever the write port handshakes. The bench samples all of these at the falling system-clock edge, counts handshakes and done pulses there, and compares the totals once the transaction has settled.

// File: rtl/qpb_pkg.sv
package qpb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WAIT,
    ST_DATA,
    ST_TAIL,
    ST_FLUSH
  } qpb_state_t;

  localparam logic [7:0] READ_OPCODE = 8'hEB;
  localparam int         HDR_CLKS    = 8;

  function automatic logic [31:0] make_header(input logic [23:0] chip_addr);
    return {READ_OPCODE, chip_addr};
  endfunction

endpackage

// File: rtl/qpb_hdr.sv
module qpb_hdr #(
  parameter int LANES = 4,
  parameter int NIB_W = 4
) (
  input  logic [31:0]            hdr,
  input  logic [2:0]             idx,
  output logic [LANES*NIB_W-1:0] lanes
);
  logic [2:0]       sel;
  logic [NIB_W-1:0] nib;

  always_comb begin
    sel = 3'd7 - idx;
    nib = hdr[{sel, 2'b00} +: 4];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g*NIB_W +: NIB_W] = nib;
  end
endmodule

// File: rtl/qpb_capture.sv
module qpb_capture #(
  parameter int DQ_W       = 16,
  parameter int SAMPLE_DLY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rise_in,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              beat_cap,
  output logic              word_vld,
  output logic [2*DQ_W-1:0] word
);
  logic [SAMPLE_DLY-1:0] pipe;
  logic [DQ_W-1:0]       hi_q;
  logic                  half_q;

  if (SAMPLE_DLY == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst || clr) pipe <= '0;
      else            pipe <= rise_in;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst || clr) pipe <= '0;
      else            pipe <= {pipe[SAMPLE_DLY-2:0], rise_in};
    end
  end

  assign beat_cap = pipe[SAMPLE_DLY-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      half_q   <= 1'b0;
      hi_q     <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (beat_cap) begin
        if (!half_q) begin
          hi_q   <= dq_i;
          half_q <= 1'b1;
        end else begin
          word     <= {hi_q, dq_i};
          word_vld <= 1'b1;
          half_q   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/qpb_fifo.sv
module qpb_fifo #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          idle
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop;

  assign pop  = (cnt != '0) && (!out_valid || out_ready);
  assign idle = (cnt == '0) && !out_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) out_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp        <= rp + 1'b1;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end
endmodule

// File: rtl/qpsram_burst_rd.sv
module qpsram_burst_rd #(
  parameter int ADDR_W     = 26,
  parameter int LEN_W      = 6,
  parameter int WAIT_CLKS  = 10,
  parameter int SAMPLE_DLY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_words,
  output logic              busy,
  output logic              done,
  output logic              mem_sck,
  output logic              mem_cs_n,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [LEN_W-1:0]  wr_idx,
  output logic [31:0]       wr_data
);
  import qpb_pkg::*;

  localparam int LANES = 4;
  localparam int DQ_W  = LANES * 4;
  localparam int BT_W  = LEN_W + 1;
  localparam int WC_W  = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WAIT_CLKS - 1);

  qpb_state_t        state;
  logic [31:0]       hdr_q;
  logic [2:0]        hcnt;
  logic [WC_W-1:0]   wcnt;
  logic [BT_W-1:0]   beats_left;
  logic [BT_W-1:0]   caps_left;
  logic [23:0]       chip_addr;
  logic [31:0]       hdr_new;
  logic [DQ_W-1:0]   next_lanes;
  logic              start;
  logic              rise_in;
  logic              beat_cap;
  logic              word_vld;
  logic [2*DQ_W-1:0] word;
  logic              buf_idle;

  assign chip_addr = 24'(req_addr >> 2);
  assign hdr_new   = make_header(chip_addr);
  assign start     = (state == ST_IDLE) && req_valid;
  assign rise_in   = (state == ST_DATA) && !mem_sck;

  qpb_hdr #(.LANES(LANES), .NIB_W(4)) u_hdr (
    .hdr  (hdr_q),
    .idx  (hcnt + 3'd1),
    .lanes(next_lanes)
  );

  qpb_capture #(.DQ_W(DQ_W), .SAMPLE_DLY(SAMPLE_DLY)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .rise_in (rise_in),
    .dq_i    (mem_dq_i),
    .beat_cap(beat_cap),
    .word_vld(word_vld),
    .word    (word)
  );

  qpb_fifo #(.DW(2*DQ_W), .AW(LEN_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .push     (word_vld),
    .push_data(word),
    .out_valid(wr_valid),
    .out_data (wr_data),
    .out_ready(wr_ready),
    .idle     (buf_idle)
  );

  always_ff @(posedge clk) begin
    if (rst || start)                wr_idx <= '0;
    else if (wr_valid && wr_ready)   wr_idx <= wr_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hdr_q      <= '0;
      hcnt       <= '0;
      wcnt       <= '0;
      beats_left <= '0;
      caps_left  <= '0;
      mem_sck    <= 1'b0;
      mem_cs_n   <= 1'b1;
      mem_dq_o   <= '0;
      mem_dq_oe  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (beat_cap && caps_left != '0) caps_left <= caps_left - 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            hdr_q      <= hdr_new;
            beats_left <= {req_words, 1'b0};
            caps_left  <= {req_words, 1'b0};
            hcnt       <= '0;
            wcnt       <= '0;
            mem_cs_n   <= 1'b0;
            mem_dq_oe  <= 1'b1;
            mem_dq_o   <= {LANES{hdr_new[31:28]}};
            busy       <= 1'b1;
            state      <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (!mem_sck) begin
            mem_sck <= 1'b1;
          end else begin
            mem_sck <= 1'b0;
            if (hcnt == 3'(HDR_CLKS - 1)) begin
              mem_dq_oe <= 1'b0;
              mem_dq_o  <= '0;
              state     <= ST_WAIT;
            end else begin
              hcnt     <= hcnt + 1'b1;
              mem_dq_o <= next_lanes;
            end
          end
        end
        ST_WAIT: begin
          if (!mem_sck) begin
            mem_sck <= 1'b1;
          end else begin
            mem_sck <= 1'b0;
            if (wcnt == WC_LAST) state <= ST_DATA;
            else                 wcnt  <= wcnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (!mem_sck) begin
            mem_sck <= 1'b1;
          end else begin
            mem_sck    <= 1'b0;
            beats_left <= beats_left - 1'b1;
            if (beats_left == BT_W'(1)) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (caps_left == '0) begin
            mem_cs_n <= 1'b1;
            state    <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (buf_idle && !word_vld) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpb_sva.sv
module qpb_sva #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             mem_sck,
  input logic             mem_cs_n,
  input logic             mem_dq_oe,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [LEN_W-1:0] wr_idx,
  input logic [31:0]      wr_data
);
  a_r3_drive_only_selected: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_cs_n);

  a_r7_clock_inside_select: assert property (@(posedge clk) disable iff (rst)
    mem_sck |-> !mem_cs_n);

  a_r7_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_cs_n && !mem_sck && !mem_dq_oe));

  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx)));

  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_cs_n && !wr_valid));
endmodule

bind qpsram_burst_rd qpb_sva #(.LEN_W(LEN_W)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mem_sck  (mem_sck),
  .mem_cs_n (mem_cs_n),
  .mem_dq_oe(mem_dq_oe),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data)
);

// File: tb/qpsram_burst_rd_test.sv
`timescale 1ns/1ps
module qpsram_burst_rd_test;
  localparam int AW = 26;
  localparam int LW = 6;
  localparam int W  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_words = '0;
  logic          busy, done, mem_sck, mem_cs_n, mem_dq_oe, wr_valid;
  logic [15:0]   mem_dq_o;
  logic [15:0]   mem_dq_i = '0;
  logic          wr_ready = 1'b1;
  logic [LW-1:0] wr_idx;
  logic [31:0]   wr_data;

  always #5 clk = ~clk;

  qpsram_burst_rd #(.ADDR_W(AW), .LEN_W(LW), .WAIT_CLKS(W), .SAMPLE_DLY(1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_words(req_words), .busy(busy), .done(done), .mem_sck(mem_sck),
    .mem_cs_n(mem_cs_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  int ntot = 0;
  int nbad = 0;
  int cyc  = 0;

  // chip model observations
  int          rises;
  logic [31:0] hdr_rx;
  bit          lane_bad, hdr_oe_bad, oe_late, cs_bad;
  // write port observations
  logic [31:0] got [64];
  int          nwr, ndone, rdy_mode, since_req;
  bit          idx_bad, busy_at_done;

  function automatic logic [15:0] beat_val(input logic [23:0] a, input int j);
    return 16'(a * 24'h3B) ^ 16'(j * 16'h1F1) ^ 16'hA5C3;
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // chip model: samples header on rising edges, drives beats 1 ns after data clocks
  always @(posedge mem_sck) begin
    rises++;
    if (mem_cs_n) cs_bad = 1'b1;
    if (rises <= 8) begin
      if (!mem_dq_oe) hdr_oe_bad = 1'b1;
      if (mem_dq_o != {4{mem_dq_o[3:0]}}) lane_bad = 1'b1;
      hdr_rx = {hdr_rx[27:0], mem_dq_o[3:0]};
    end else if (mem_dq_oe) begin
      oe_late = 1'b1;
    end
    if (rises > 8 + W) begin
      #1 mem_dq_i = beat_val(hdr_rx[23:0], rises - 9 - W);
    end
  end

  // write port sink, sampled at the falling edge
  always @(negedge clk) begin
    since_req++;
    if (rdy_mode == 0) wr_ready = 1'b1;
    else               wr_ready = (since_req > 30) && (since_req % 3 != 0);
    if (wr_valid && wr_ready) begin
      if (wr_idx != LW'(nwr)) idx_bad = 1'b1;
      got[nwr % 64] = wr_data;
      nwr++;
    end
    if (done) begin
      ndone++;
      busy_at_done = busy;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++; ntot++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  task automatic clear_obs();
    rises = 0; hdr_rx = '0; lane_bad = 0; hdr_oe_bad = 0; oe_late = 0; cs_bad = 0;
    nwr = 0; ndone = 0; idx_bad = 0; busy_at_done = 1; since_req = 0;
  endtask

  // issue one request and check everything about it
  task automatic run_req(input string name, input logic [AW-1:0] a, input int n,
                         input int mode, input bit inject);
    logic [23:0] ea;
    int guard;
    int firstbad;
    ea = 24'(a >> 2);
    clear_obs();
    rdy_mode = mode;
    @(negedge clk);
    req_addr = a; req_words = LW'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({name, " R9 busy after accept"}, busy == 1'b1, busy, 1);
    if (inject) begin
      repeat (10) @(negedge clk);
      req_addr = a ^ 26'h0ABCDE0; req_words = LW'(1); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (ndone == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (25) @(negedge clk);
    chk({name, " R1 opcode"}, hdr_rx[31:24] == 8'hEB, hdr_rx[31:24], 8'hEB);
    chk({name, " R1 chip address"}, hdr_rx[23:0] == ea, hdr_rx[23:0], ea);
    chk({name, " R2 lanes equal"}, !lane_bad, lane_bad, 0);
    chk({name, " R3 enable in header"}, !hdr_oe_bad, hdr_oe_bad, 0);
    chk({name, " R3 released after header"}, !oe_late, oe_late, 0);
    chk({name, " R5 clock count"}, rises == 8 + W + 2*n, rises, 8 + W + 2*n);
    chk({name, " R7 select low on clocks"}, !cs_bad, cs_bad, 0);
    chk({name, " R8 word count"}, nwr == n, nwr, n);
    chk({name, " R6 index order"}, !idx_bad, idx_bad, 0);
    firstbad = -1;
    for (int i = 0; i < n && i < 64; i++) begin
      if (firstbad < 0 && got[i] != {beat_val(ea, 2*i), beat_val(ea, 2*i+1)}) firstbad = i;
    end
    // R4: wrong wait count shifts every beat, so data order covers it
    chk({name, " R4/R6 data"}, firstbad < 0,
        (firstbad < 0) ? 0 : got[firstbad],
        (firstbad < 0) ? 0 : {beat_val(ea, 2*firstbad), beat_val(ea, 2*firstbad+1)});
    chk({name, " R10 one done"}, ndone == 1, ndone, 1);
    chk({name, " R9 busy low at done"}, busy_at_done == 1'b0, busy_at_done, 0);
    chk({name, " R7 idle levels"}, mem_cs_n && !mem_sck && !mem_dq_oe,
        {mem_cs_n, mem_sck, mem_dq_oe}, 3'b100);
  endtask

  task automatic t_reset();
    chk("R11 cs_n", mem_cs_n == 1'b1, mem_cs_n, 1);
    chk("R11 sck", mem_sck == 1'b0, mem_sck, 0);
    chk("R11 oe", mem_dq_oe == 1'b0, mem_dq_oe, 0);
    chk("R11 busy/done/valid", {busy, done, wr_valid} == 3'b000, {busy, done, wr_valid}, 0);
  endtask

  task automatic t_basic();         run_req("basic",   26'h0000100, 4, 0, 0); endtask
  task automatic t_backpressure();  run_req("stall",   26'h0002000, 6, 1, 0); endtask
  task automatic t_reload();
    run_req("reload long",  26'h0011230, 8, 0, 0);
    run_req("reload short", 26'h0011240, 1, 0, 0); // R8
  endtask
  task automatic t_busy_ignore();   run_req("busy R9", 26'h0300044, 3, 0, 1); endtask
  task automatic t_max();           run_req("max",     26'h3FFFFFC, 63, 1, 0); endtask

  initial begin
    clear_obs();
    rdy_mode = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_reload();
    t_busy_ignore();
    t_max();
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule